// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for a small set of memory blocks in a distributed shared-memory system with `N_NODES` processor nodes. For each block it keeps a presence bit per node and a coherence state: uncached, shared or dirty. Cache controllers send it read misses, write misses, write-backs and acknowledgements, and it returns one message per accepted request. That message is one of: a data reply, a write grant, an invalidation, an owner fetch, an owner fetch-and-invalidate, or a negative acknowledgement.

Outgoing messages carry a destination node mask, so one message can invalidate several sharers at once. A block that is waiting for acknowledgements is marked busy. Any new read or write miss to a busy block gets a negative acknowledgement and the requester must retry. Requests to other blocks are served as normal. The block assumes that messages between two nodes arrive in the order they were sent. Data storage and routing are outside this block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached, no node is present and no block is busy, and `rsp_valid_o` is low until a request is accepted.
- R2: A read miss (type 0) to a non-busy uncached or shared block is answered one cycle later with DATA (type 1) to the requester only. The requester becomes present and the block becomes shared.
- R3: A read miss to a non-busy dirty block owned by another node sends FETCH (type 4) to the owner and makes the block busy. The owner's acknowledgement (type 3) produces DATA to the original requester, and afterwards the owner and the requester are both present in shared state.
- R4: A write miss (type 1) to a non-busy uncached block is answered one cycle later with GRANT (type 2) to the requester. The block becomes dirty with the requester as its only holder.
- R5: A write miss to a shared block that has other holders sends INV (type 3) once, with a destination mask holding every present node except the requester. Each matching acknowledgement removes that node. GRANT goes to the requester only in the cycle after the last expected acknowledgement.
- R6: A write miss from a node that is the only holder of a shared block is granted at once, with no invalidation.
- R7: A write miss to a dirty block owned by another node sends FETCH_INV (type 5) to the owner. GRANT follows the owner's acknowledgement, and the requester becomes the sole owner.
- R8: A read or write miss to a busy block is answered with NACK (type 6) to the requester and leaves that block unchanged. Requests to other blocks are handled normally in the meantime.
- R9: A write-back (type 2) from the dirty owner of a non-busy block returns the block to uncached with no node present. A write-back from any other node is ignored. No write-back produces a response.
- R10: An acknowledgement to a block that is not busy, or from a node not expected to acknowledge, or repeated, produces no response and changes nothing.
- R11: A dirty block always has exactly one present node, and an uncached block has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request message present this cycle |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 acknowledgement |
| req_src_i | input | $clog2(N_NODES) | Sending node |
| req_blk_i | input | $clog2(N_BLOCKS) | Addressed block |
| rsp_valid_o | output | 1 | Response message present |
| rsp_type_o | output | 3 | 1 DATA, 2 GRANT, 3 INV, 4 FETCH, 5 FETCH_INV, 6 NACK |
| rsp_dst_o | output | N_NODES | Destination node mask |
| rsp_blk_o | output | $clog2(N_BLOCKS) | Block the message concerns |

## Verification
The block is driven through read-sharing buildup, write misses that hit uncached, sole-holder, multi-sharer and dirty blocks, and reads of dirty blocks. Each pattern separates a path that grants at once from one that must wait for acknowledgements.

Requests aimed at a block while it waits are checked to get NACK, while the same requests to a neighbouring block are still served. This shows that the busy marking is kept per block and not shared across blocks.

Stray, duplicate and early acknowledgements, as well as write-backs from non-owners, are interleaved with the other traffic. Follow-up reads then show whether the directory state was left untouched.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHD = 2'd1, ST_DRT = 2'd2} dir_st_e;
  typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_WB = 2'd2, RQ_ACK = 2'd3} req_e;
  typedef enum logic [2:0] {
    RS_NONE = 3'd0, RS_DATA = 3'd1, RS_GRANT = 3'd2, RS_INV = 3'd3,
    RS_FETCH = 3'd4, RS_FETCH_INV = 3'd5, RS_NACK = 3'd6
  } rsp_e;
endpackage

// File: rtl/dir_entry_file.sv
module dir_entry_file
  import dir_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 4,
  localparam int NW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BW-1:0]      blk_i,
  input  logic               wr_en_i,
  input  dir_st_e            nxt_st_i,
  input  logic [N_NODES-1:0] nxt_pres_i,
  input  logic               nxt_busy_i,
  input  logic [NW-1:0]      nxt_psrc_i,
  input  logic               nxt_pwr_i,
  input  logic [N_NODES-1:0] nxt_pmask_i,
  output dir_st_e            cur_st_o,
  output logic [N_NODES-1:0] cur_pres_o,
  output logic               cur_busy_o,
  output logic [NW-1:0]      cur_psrc_o,
  output logic               cur_pwr_o,
  output logic [N_NODES-1:0] cur_pmask_o
);
  dir_st_e            st_q    [N_BLOCKS];
  logic [N_NODES-1:0] pres_q  [N_BLOCKS];
  logic               busy_q  [N_BLOCKS];
  logic [NW-1:0]      psrc_q  [N_BLOCKS];
  logic               pwr_q   [N_BLOCKS];
  logic [N_NODES-1:0] pmask_q [N_BLOCKS];

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[b]    <= ST_UNC;
        pres_q[b]  <= '0;
        busy_q[b]  <= 1'b0;
        psrc_q[b]  <= '0;
        pwr_q[b]   <= 1'b0;
        pmask_q[b] <= '0;
      end else if (wr_en_i && blk_i == BW'(b)) begin
        st_q[b]    <= nxt_st_i;
        pres_q[b]  <= nxt_pres_i;
        busy_q[b]  <= nxt_busy_i;
        psrc_q[b]  <= nxt_psrc_i;
        pwr_q[b]   <= nxt_pwr_i;
        pmask_q[b] <= nxt_pmask_i;
      end
    end

    p_dirty_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q[b] == ST_DRT |-> $onehot(pres_q[b]));
    p_unc_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q[b] == ST_UNC |-> (pres_q[b] == '0 && !busy_q[b]));
  end

  assign cur_st_o    = st_q[blk_i];
  assign cur_pres_o  = pres_q[blk_i];
  assign cur_busy_o  = busy_q[blk_i];
  assign cur_psrc_o  = psrc_q[blk_i];
  assign cur_pwr_o   = pwr_q[blk_i];
  assign cur_pmask_o = pmask_q[blk_i];
endmodule

// File: rtl/dir_next_state.sv
module dir_next_state
  import dir_pkg::*;
#(
  parameter int N_NODES = 4,
  localparam int NW = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               req_valid_i,
  input  logic [1:0]         req_type_i,
  input  logic [NW-1:0]      req_src_i,
  input  dir_st_e            cur_st_i,
  input  logic [N_NODES-1:0] cur_pres_i,
  input  logic               cur_busy_i,
  input  logic [NW-1:0]      cur_psrc_i,
  input  logic               cur_pwr_i,
  input  logic [N_NODES-1:0] cur_pmask_i,
  output logic               wr_en_o,
  output dir_st_e            nxt_st_o,
  output logic [N_NODES-1:0] nxt_pres_o,
  output logic               nxt_busy_o,
  output logic [NW-1:0]      nxt_psrc_o,
  output logic               nxt_pwr_o,
  output logic [N_NODES-1:0] nxt_pmask_o,
  output logic               rsp_valid_o,
  output rsp_e               rsp_type_o,
  output logic [N_NODES-1:0] rsp_dst_o
);
  logic [N_NODES-1:0] src_m, psrc_m, others, left;
  req_e rq;

  always_comb begin
    src_m  = '0;
    src_m[req_src_i] = 1'b1;
    psrc_m = '0;
    psrc_m[cur_psrc_i] = 1'b1;
    others = cur_pres_i & ~src_m;
    left   = cur_pmask_i & ~src_m;
    rq     = req_e'(req_type_i);

    wr_en_o     = 1'b0;
    nxt_st_o    = cur_st_i;
    nxt_pres_o  = cur_pres_i;
    nxt_busy_o  = cur_busy_i;
    nxt_psrc_o  = cur_psrc_i;
    nxt_pwr_o   = cur_pwr_i;
    nxt_pmask_o = cur_pmask_i;
    rsp_valid_o = 1'b0;
    rsp_type_o  = RS_NONE;
    rsp_dst_o   = '0;

    if (req_valid_i) begin
      unique case (rq)
        RQ_RD, RQ_WR: begin
          if (cur_busy_i) begin
            rsp_valid_o = 1'b1;
            rsp_type_o  = RS_NACK;
            rsp_dst_o   = src_m;
          end else if (rq == RQ_RD) begin
            rsp_valid_o = 1'b1;
            if (cur_st_i == ST_DRT && others != '0) begin
              // fetch from remote owner first
              rsp_type_o  = RS_FETCH;
              rsp_dst_o   = others;
              wr_en_o     = 1'b1;
              nxt_busy_o  = 1'b1;
              nxt_psrc_o  = req_src_i;
              nxt_pwr_o   = 1'b0;
              nxt_pmask_o = others;
            end else if (cur_st_i == ST_DRT) begin
              rsp_type_o = RS_DATA;
              rsp_dst_o  = src_m;
            end else begin
              rsp_type_o = RS_DATA;
              rsp_dst_o  = src_m;
              wr_en_o    = 1'b1;
              nxt_st_o   = ST_SHD;
              nxt_pres_o = cur_pres_i | src_m;
            end
          end else begin
            rsp_valid_o = 1'b1;
            if (others == '0) begin
              rsp_type_o = RS_GRANT;
              rsp_dst_o  = src_m;
              wr_en_o    = 1'b1;
              nxt_st_o   = ST_DRT;
              nxt_pres_o = src_m;
            end else begin
              rsp_type_o  = (cur_st_i == ST_DRT) ? RS_FETCH_INV : RS_INV;
              rsp_dst_o   = others;
              wr_en_o     = 1'b1;
              nxt_busy_o  = 1'b1;
              nxt_psrc_o  = req_src_i;
              nxt_pwr_o   = 1'b1;
              nxt_pmask_o = others;
            end
          end
        end
        RQ_WB: begin
          if (!cur_busy_i && cur_st_i == ST_DRT && cur_pres_i == src_m) begin
            wr_en_o    = 1'b1;
            nxt_st_o   = ST_UNC;
            nxt_pres_o = '0;
          end
        end
        RQ_ACK: begin
          if (cur_busy_i && (cur_pmask_i & src_m) != '0) begin
            wr_en_o     = 1'b1;
            nxt_pmask_o = left;
            if (cur_pwr_i) nxt_pres_o = cur_pres_i & ~src_m;
            if (left == '0) begin
              nxt_busy_o  = 1'b0;
              rsp_valid_o = 1'b1;
              rsp_dst_o   = psrc_m;
              if (cur_pwr_i) begin
                rsp_type_o = RS_GRANT;
                nxt_st_o   = ST_DRT;
                nxt_pres_o = psrc_m;
              end else begin
                rsp_type_o = RS_DATA;
                nxt_st_o   = ST_SHD;
                nxt_pres_o = cur_pres_i | psrc_m;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dir_rsp_reg.sv
module dir_rsp_reg
  import dir_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int BW      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  rsp_e               type_i,
  input  logic [N_NODES-1:0] dst_i,
  input  logic [BW-1:0]      blk_i,
  output logic               valid_o,
  output logic [2:0]         type_o,
  output logic [N_NODES-1:0] dst_o,
  output logic [BW-1:0]      blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      type_o  <= '0;
      dst_o   <= '0;
      blk_o   <= '0;
    end else begin
      valid_o <= valid_i;
      type_o  <= valid_i ? type_i : RS_NONE;
      dst_o   <= valid_i ? dst_i : '0;
      blk_o   <= blk_i;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 4,
  localparam int NW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_type_i,
  input  logic [NW-1:0]      req_src_i,
  input  logic [BW-1:0]      req_blk_i,
  output logic               rsp_valid_o,
  output logic [2:0]         rsp_type_o,
  output logic [N_NODES-1:0] rsp_dst_o,
  output logic [BW-1:0]      rsp_blk_o
);
  dir_st_e            cur_st, nxt_st;
  logic [N_NODES-1:0] cur_pres, nxt_pres, cur_pmask, nxt_pmask, ns_dst;
  logic               cur_busy, nxt_busy, cur_pwr, nxt_pwr, wr_en, ns_valid;
  logic [NW-1:0]      cur_psrc, nxt_psrc;
  rsp_e               ns_type;

  dir_entry_file #(.N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS)) i_entries (
    .clk_i, .rst_ni, .blk_i(req_blk_i), .wr_en_i(wr_en),
    .nxt_st_i(nxt_st), .nxt_pres_i(nxt_pres), .nxt_busy_i(nxt_busy),
    .nxt_psrc_i(nxt_psrc), .nxt_pwr_i(nxt_pwr), .nxt_pmask_i(nxt_pmask),
    .cur_st_o(cur_st), .cur_pres_o(cur_pres), .cur_busy_o(cur_busy),
    .cur_psrc_o(cur_psrc), .cur_pwr_o(cur_pwr), .cur_pmask_o(cur_pmask)
  );

  dir_next_state #(.N_NODES(N_NODES)) i_next (
    .req_valid_i, .req_type_i, .req_src_i,
    .cur_st_i(cur_st), .cur_pres_i(cur_pres), .cur_busy_i(cur_busy),
    .cur_psrc_i(cur_psrc), .cur_pwr_i(cur_pwr), .cur_pmask_i(cur_pmask),
    .wr_en_o(wr_en), .nxt_st_o(nxt_st), .nxt_pres_o(nxt_pres),
    .nxt_busy_o(nxt_busy), .nxt_psrc_o(nxt_psrc), .nxt_pwr_o(nxt_pwr),
    .nxt_pmask_o(nxt_pmask),
    .rsp_valid_o(ns_valid), .rsp_type_o(ns_type), .rsp_dst_o(ns_dst)
  );

  dir_rsp_reg #(.N_NODES(N_NODES), .BW(BW)) i_rsp (
    .clk_i, .rst_ni, .valid_i(ns_valid), .type_i(ns_type), .dst_i(ns_dst),
    .blk_i(req_blk_i), .valid_o(rsp_valid_o), .type_o(rsp_type_o),
    .dst_o(rsp_dst_o), .blk_o(rsp_blk_o)
  );

  p_nack_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && cur_busy && (req_type_i == 2'd0 || req_type_i == 2'd1)
    |=> rsp_valid_o && rsp_type_o == 3'd6);
  p_grant_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_type_o == 3'd2 |-> $onehot(rsp_dst_o));
  p_wb_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i == 2'd2 |=> !rsp_valid_o);
  p_ack_no_nack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i == 2'd3 |=> rsp_type_o != 3'd6);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int N  = 4;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [1:0] req_src = '0;
  logic [1:0] req_blk = '0;
  logic       rsp_valid;
  logic [2:0] rsp_type;
  logic [N-1:0] rsp_dst;
  logic [1:0] rsp_blk;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.N_NODES(N), .N_BLOCKS(NB)) i_dir_home_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_src_i(req_src), .req_blk_i(req_blk), .rsp_valid_o(rsp_valid),
    .rsp_type_o(rsp_type), .rsp_dst_o(rsp_dst), .rsp_blk_o(rsp_blk)
  );

  // behavioural directory: 0 uncached, 1 shared, 2 dirty
  int       m_st    [NB];
  bit [N-1:0] m_pres [NB];
  bit       m_busy  [NB];
  int       m_req   [NB];
  bit       m_wr    [NB];
  bit [N-1:0] m_wait [NB];

  bit       e_valid = 0;
  int       e_type = 0;
  bit [N-1:0] e_dst = '0;
  int       e_blk = 0;
  string    e_tag = "R1";

  task automatic model(input int t, input int s, input int b);
    bit [N-1:0] me, oth;
    me = '0; me[s] = 1'b1;
    oth = m_pres[b] & ~me;
    e_valid = 0; e_type = 0; e_dst = '0; e_blk = b;
    if (t == 0 || t == 1) begin
      e_valid = 1;
      if (m_busy[b]) begin e_type = 6; e_dst = me; end
      else if (t == 0) begin
        if (m_st[b] == 2 && oth != 0) begin
          e_type = 4; e_dst = oth; m_busy[b] = 1; m_req[b] = s; m_wr[b] = 0; m_wait[b] = oth;
        end else if (m_st[b] == 2) begin e_type = 1; e_dst = me; end
        else begin e_type = 1; e_dst = me; m_st[b] = 1; m_pres[b] |= me; end
      end else begin
        if (oth == 0) begin e_type = 2; e_dst = me; m_st[b] = 2; m_pres[b] = me; end
        else begin
          e_type = (m_st[b] == 2) ? 5 : 3; e_dst = oth;
          m_busy[b] = 1; m_req[b] = s; m_wr[b] = 1; m_wait[b] = oth;
        end
      end
    end else if (t == 2) begin
      if (!m_busy[b] && m_st[b] == 2 && m_pres[b] == me) begin m_st[b] = 0; m_pres[b] = '0; end
    end else begin
      if (m_busy[b] && m_wait[b][s]) begin
        m_wait[b][s] = 1'b0;
        if (m_wr[b]) m_pres[b][s] = 1'b0;
        if (m_wait[b] == 0) begin
          m_busy[b] = 0; e_valid = 1; e_dst = '0; e_dst[m_req[b]] = 1'b1;
          if (m_wr[b]) begin e_type = 2; m_st[b] = 2; m_pres[b] = e_dst; end
          else begin e_type = 1; m_st[b] = 1; m_pres[b] |= e_dst; end
        end
      end
    end
  endtask

  // one cycle: check the previous step's response, then drive the next request
  task automatic step(input bit v, input int t, input int s, input int b, input string tag);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== e_valid || (e_valid && (int'(rsp_type) != e_type || rsp_dst !== e_dst
        || int'(rsp_blk) != e_blk))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b t=%0d dst=%b blk=%0d, expected v=%0b t=%0d dst=%b blk=%0d",
               e_tag, rsp_valid, rsp_type, rsp_dst, rsp_blk, e_valid, e_type, e_dst, e_blk);
    end
    req_valid = v; req_type = 2'(t); req_src = 2'(s); req_blk = 2'(b);
    e_tag = tag;
    if (v) model(t, s, b);
    else begin e_valid = 0; e_type = 0; e_dst = '0; end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_st[i] = 0; m_pres[i] = '0; m_busy[i] = 0; m_req[i] = 0; m_wr[i] = 0; m_wait[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    // read sharing
    step(1, 0, 0, 0, "R2");
    step(1, 0, 1, 0, "R2");
    // write with two other sharers
    step(1, 1, 2, 0, "R5");
    step(1, 0, 3, 0, "R8");
    step(1, 0, 3, 1, "R8");
    step(1, 3, 0, 0, "R5");
    step(1, 3, 0, 0, "R10");
    step(1, 3, 1, 0, "R5");
    // read of dirty block
    step(1, 0, 0, 0, "R3 R11");
    step(1, 3, 1, 0, "R10");
    step(1, 3, 2, 0, "R3");
    step(1, 1, 0, 0, "R5");
    step(1, 3, 2, 0, "R5");
    // write to dirty block held elsewhere
    step(1, 1, 1, 0, "R7");
    step(1, 3, 0, 0, "R7");
    step(1, 2, 3, 0, "R9");
    step(1, 0, 2, 0, "R9 R3");
    step(1, 3, 1, 0, "R3");
    // uncached write, write-back, sole sharer upgrade
    step(1, 1, 3, 2, "R4");
    step(1, 2, 3, 2, "R9");
    step(1, 0, 0, 2, "R9 R2");
    step(1, 1, 0, 2, "R6");
    step(1, 0, 1, 3, "R2");
    step(1, 1, 1, 3, "R6");
    step(1, 3, 1, 3, "R10");
    // nack of a write to a busy block
    step(1, 1, 2, 1, "R5");
    step(1, 1, 0, 1, "R8");
    step(1, 3, 3, 1, "R5");
    step(1, 2, 2, 1, "R9 R11");
    step(1, 0, 0, 1, "R9");
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule